// File: doc/BRIEF.md
# Loop Error Built-In-Test Monitor

This block watches a tracking angle converter and drives an active-low health flag. Each clock it looks at three inputs. The first is the signed loop error, counted in LSBs of the resolution in use. The second is a loss-of-signal indication. The third, used only when the reference-synthesis variant is built, is a loss-of-reference indication. From these it forms a raw fault condition. The raw fault is true when the error magnitude is above a threshold, which is about 100 LSBs by default, or when either loss input is high. A large error appears after a big input step. It also appears during overvelocity, when the loop can no longer stay in step and its error runs to the end of its range.

The raw condition does not drive the flag directly. A qualification counter sits between them. The flag changes state only after the raw condition has disagreed with the flag for a full qualification window of consecutive clocks. If the raw condition returns to agreement before the window ends, the counter restarts from zero. The same window applies both when the flag goes into fault and when it leaves fault. This means a short spike does not flag, and a loop that is settling does not make the flag chatter. The window length is set in microseconds and converted to clock cycles from the clock frequency parameter. The default window is 500 µs.

Top module: `bit_monitor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `bit_n` is 1 (no fault), whatever the other inputs are.
- R2: The loop error counts as a fault only when its magnitude is strictly greater than `THRESH`. With the default threshold of 100, the values +101 and -101 qualify, and +100 and -100 do not.
- R3: The most negative error code (-2^(ERR_W-1), which is -2048 when `ERR_W` is 12) and the most positive code (+2047) both count as faults. This covers the overvelocity case, where the error runs to full scale.
- R4: When `sig_lost` is 1, the raw condition is a fault for any value of the loop error.
- R5: When `REF_SYNTH` is 1, `ref_lost` = 1 is a fault. When `REF_SYNTH` is 0, `ref_lost` has no effect on `bit_n`.
- R6: `bit_n` goes to 0 at the FILT_CYC-th rising edge at which the raw fault is seen without a break. After FILT_CYC-1 such edges it is still 1.
- R7: If the raw fault drops for even one cycle before the window completes, the count restarts. Two runs of FILT_CYC-1 cycles separated by one clear cycle do not raise the fault.
- R8: Once in fault, `bit_n` returns to 1 at the FILT_CYC-th consecutive rising edge with no raw fault, and not before.
- R9: FILT_CYC = (CLK_HZ / 1_000_000) * FILT_US, with a minimum of 1. For example, CLK_HZ = 1 MHz and FILT_US = 16 give 16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one qualification count per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_err | input | ERR_W | Signed loop error in LSBs of the active resolution |
| sig_lost | input | 1 | High when the input signal is lost |
| ref_lost | input | 1 | High when the reference is lost (used only if REF_SYNTH = 1) |
| bit_n | output | 1 | Built-in-test flag, 0 = fault |

## Verification
The hardest behaviour to reach from the ports is the restart of the qualification count. The raw condition must be held for exactly one cycle short of the window, dropped for a single cycle, and then held short again. Any off-by-one in the counter then shows up as a spurious fault. The bench drives inputs on falling edges and counts rising edges exactly. It samples the flag one edge before, and on, the expected switching edge. The most negative error code is applied on its own, because a two's-complement magnitude that wraps would read it as a small value.

// File: rtl/bit_monitor.sv
module bit_monitor #(
  parameter int ERR_W     = 17,
  parameter int THRESH    = 100,
  parameter int CLK_HZ    = 50_000_000,
  parameter int FILT_US   = 500,
  parameter bit REF_SYNTH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] loop_err,
  input  logic             sig_lost,
  input  logic             ref_lost,
  output logic             bit_n
);

  localparam int FILT_RAW = (CLK_HZ / 1_000_000) * FILT_US;
  localparam int FILT_CYC = (FILT_RAW < 1) ? 1 : FILT_RAW;
  localparam int CW       = $clog2(FILT_CYC + 1);

  logic [ERR_W:0] err_x;
  logic [ERR_W:0] mag;
  logic           over_err;
  logic           ref_fault;
  logic           raw;
  logic           fault_q;
  logic [CW-1:0]  cnt;

  assign err_x     = {loop_err[ERR_W-1], loop_err};
  assign mag       = loop_err[ERR_W-1] ? (~err_x + 1'b1) : err_x;
  assign over_err  = mag > (ERR_W+1)'(THRESH);
  assign ref_fault = REF_SYNTH && ref_lost;
  assign raw       = over_err | sig_lost | ref_fault;
  assign bit_n     = ~fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      cnt     <= '0;
    end else if (raw == fault_q) begin
      cnt <= '0;
    end else if (cnt == CW'(FILT_CYC - 1)) begin
      fault_q <= raw;
      cnt     <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bit_monitor_chk.sv
module bit_monitor_chk #(
  parameter int ERR_W     = 17,
  parameter int THRESH    = 100,
  parameter int CLK_HZ    = 50_000_000,
  parameter int FILT_US   = 500,
  parameter bit REF_SYNTH = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ERR_W-1:0] loop_err,
  input logic             sig_lost,
  input logic             ref_lost,
  input logic             bit_n
);

  localparam int FRAW = (CLK_HZ / 1_000_000) * FILT_US;
  localparam int FCYC = (FRAW < 1) ? 1 : FRAW;

  logic signed [ERR_W-1:0] serr;
  logic                    want;
  int                      run;
  logic                    seen_rst;

  assign serr = loop_err;
  assign want = (int'(serr) > THRESH) || (int'(serr) < -THRESH) || sig_lost || (REF_SYNTH && ref_lost);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 0;
      seen_rst <= 1'b1;
    end else if ((want == bit_n) && (run < FCYC)) begin
      run <= run + 1;
    end else begin
      run <= 0;
    end
  end

  // R6
  fall_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bit_n) |-> $past(want));

  // R8
  rise_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_n) |-> !$past(want));

  // R7
  full_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bit_n) || $fell(bit_n)) |-> ($past(run) == FCYC - 1));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    (seen_rst && $past(!rst_n)) |-> bit_n);

endmodule

bind bit_monitor bit_monitor_chk #(
  .ERR_W(ERR_W), .THRESH(THRESH), .CLK_HZ(CLK_HZ),
  .FILT_US(FILT_US), .REF_SYNTH(REF_SYNTH)
) u_chk (.*);

// File: tb/tb_bit_monitor.sv
module tb_bit_monitor;
  localparam int W = 12;
  localparam int F = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] loop_err = '0;
  logic         sig_lost = 1'b0;
  logic         ref_lost = 1'b0;
  logic         bit_n, bit_n_nr;
  int           checks = 0;
  int           fails = 0;

  always #10 clk = ~clk;

  bit_monitor #(.ERR_W(W), .THRESH(100), .CLK_HZ(1_000_000), .FILT_US(F), .REF_SYNTH(1'b1))
    dut (.clk(clk), .rst_n(rst_n), .loop_err(loop_err), .sig_lost(sig_lost),
         .ref_lost(ref_lost), .bit_n(bit_n));

  bit_monitor #(.ERR_W(W), .THRESH(100), .CLK_HZ(1_000_000), .FILT_US(F), .REF_SYNTH(1'b0))
    dut_noref (.clk(clk), .rst_n(rst_n), .loop_err(loop_err), .sig_lost(sig_lost),
               .ref_lost(ref_lost), .bit_n(bit_n_nr));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: bit_n=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input int e, input logic los, input logic lor);
    @(negedge clk);
    loop_err = W'(e);
    sig_lost = los;
    ref_lost = lor;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_flip(input string req, input logic exp_after);
    repeat (F - 1) @(posedge clk);
    @(negedge clk);
    chk({req, " before window (R9)"}, bit_n, ~exp_after);
    @(posedge clk);
    @(negedge clk);
    chk({req, " at window (R9)"}, bit_n, exp_after);
  endtask

  task automatic t_reset();
    loop_err = W'(500);
    sig_lost = 1'b1;
    wait_cyc(3 * F);
    chk("R1 in reset", bit_n, 1'b1);
    apply(0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 after release", bit_n, 1'b1);
  endtask

  task automatic t_pos_thresh();
    apply(100, 1'b0, 1'b0);
    wait_cyc(3 * F);
    chk("R2 +100 no fault", bit_n, 1'b1);
    apply(101, 1'b0, 1'b0);
    expect_flip("R2 R6 +101", 1'b0);
    apply(0, 1'b0, 1'b0);
    expect_flip("R8 clear", 1'b1);
  endtask

  task automatic t_neg_thresh();
    apply(-100, 1'b0, 1'b0);
    wait_cyc(3 * F);
    chk("R2 -100 no fault", bit_n, 1'b1);
    apply(-101, 1'b0, 1'b0);
    expect_flip("R2 -101", 1'b0);
    apply(-100, 1'b0, 1'b0);
    expect_flip("R8 clear to -100", 1'b1);
  endtask

  task automatic t_full_scale();
    apply(-2048, 1'b0, 1'b0);
    expect_flip("R3 most negative", 1'b0);
    apply(2047, 1'b0, 1'b0);
    wait_cyc(2 * F);
    chk("R3 most positive holds fault", bit_n, 1'b0);
    apply(3, 1'b0, 1'b0);
    expect_flip("R8 clear after full scale", 1'b1);
  endtask

  task automatic t_restart();
    apply(300, 1'b0, 1'b0);
    wait_cyc(F - 2);
    apply(0, 1'b0, 1'b0);
    chk("R7 first short run", bit_n, 1'b1);
    apply(300, 1'b0, 1'b0);
    wait_cyc(F - 2);
    apply(0, 1'b0, 1'b0);
    chk("R7 second short run", bit_n, 1'b1);
    wait_cyc(2 * F);
    chk("R7 no fault after gaps", bit_n, 1'b1);
    apply(300, 1'b0, 1'b0);
    expect_flip("R6 unbroken run", 1'b0);
    apply(0, 1'b0, 1'b0);
    wait_cyc(F - 2);
    apply(300, 1'b0, 1'b0);
    chk("R8 short clear keeps fault", bit_n, 1'b0);
    apply(0, 1'b0, 1'b0);
    expect_flip("R8 full clear", 1'b1);
  endtask

  task automatic t_sig_lost();
    apply(0, 1'b1, 1'b0);
    expect_flip("R4 signal loss", 1'b0);
    chk("R4 signal loss no-ref variant", bit_n_nr, 1'b0);
    apply(0, 1'b0, 1'b0);
    expect_flip("R4 signal restored", 1'b1);
  endtask

  task automatic t_ref_lost();
    apply(0, 1'b0, 1'b1);
    expect_flip("R5 reference loss", 1'b0);
    chk("R5 no-ref variant ignores loss", bit_n_nr, 1'b1);
    wait_cyc(2 * F);
    chk("R5 no-ref variant still clear", bit_n_nr, 1'b1);
    apply(0, 1'b0, 1'b0);
    expect_flip("R5 reference restored", 1'b1);
  endtask

  initial begin
    t_reset();
    t_pos_thresh();
    t_neg_thresh();
    t_full_scale();
    t_restart();
    t_sig_lost();
    t_ref_lost();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule